// File: doc/BRIEF.md
# Legacy I/O Port Address Decoder

This block turns a legacy I/O port access into a physical address and a target-select code. The request gives a port number, an access size in bytes, a write flag and write data. One port gives full-width access to a 32-bit configuration-address register held inside the block. Four consecutive ports form the configuration-data window. An access to that window goes to a configuration-space address, which is built from the stored configuration address, but only while that register's enable bit is set. Every other legal port is placed in a generic I/O region.

The decode is combinational and feeds one output register stage. A request is accepted in every cycle in which `req_valid` is high. The configuration-address register changes on the same clock edge that registers the response to the write. The following request therefore sees the new value.

Top module: `io_port_decoder`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rsp_valid` is 0, `rsp_target` is 0, and `rsp_paddr` and `rsp_rdata` are 0. The configuration-address register is cleared, so a later read of port 0x0CF8 with size 4 returns 0.
- R2: If any port bit above bit 15 is set, the target code is 4 (illegal), `rsp_paddr` is 0 and `rsp_rdata` is 0. Such a request, even a size-4 write, leaves the configuration-address register unchanged.
- R3: An access to port 0x0CF8 with size 4 has target code 1 (configuration-address register) and `rsp_paddr` 0. On a read, `rsp_rdata` is the register's current value.
- R4: A write to port 0x0CF8 with size 4 loads `req_wdata` into the configuration-address register. The very next request observes the new value.
- R5: An access to port 0x0CF8 with any size other than 4 is decoded as an ordinary I/O port (target code 0, `rsp_paddr` = IO_BASE | port). It does not change the configuration-address register.
- R6: An access to ports 0x0CFC to 0x0CFF, of any size, while bit 31 of the configuration-address register is 1, has target code 2. `rsp_paddr` is CFG_BASE | register bits 30:0; the low port bits are not added.
- R7: The same window access while bit 31 is 0 has target code 3 (no target) and `rsp_paddr` 0. On a read, `rsp_rdata` is 0xFFFFFFFF.
- R8: Every other port below 0x10000 has target code 0 and `rsp_paddr` = IO_BASE | port. This includes 0x0CFB and 0x0D00, the ports on each side of the window. `rsp_rdata` is 0 for writes and for every target not named in R3 and R7.
- R9: Each response appears exactly one cycle after its request. `rsp_valid` follows `req_valid` with one cycle of delay, and back-to-back requests each receive their own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 32 | Port number; bits above 15 must be 0 |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_target | output | 3 | 0 I/O, 1 config-address register, 2 config space, 3 no target, 4 illegal |
| rsp_paddr | output | 64 | Physical address |
| rsp_rdata | output | 32 | Read data for register reads and no-target reads |

## Verification
Target code, address and read data are all due one clock edge after the request. The bench drives each request on a falling edge and samples shortly after the next rising edge. A write to the configuration-address register becomes visible to the very next request. The stimulus table therefore places a write and the read or window access that depends on it in consecutive cycles, with no idle cycle between them. The reset checks clear the register in the middle of the run and read it back one cycle later.

// File: rtl/io_dec_pkg.sv
// Shared target codes and fixed port numbers for the I/O port decoder.
package io_dec_pkg;
    typedef enum logic [2:0] {
        TGT_IO        = 3'd0,
        TGT_CFG_ADDR  = 3'd1,
        TGT_CFG_SPACE = 3'd2,
        TGT_NONE      = 3'd3,
        TGT_ILLEGAL   = 3'd4
    } io_tgt_e;

    localparam logic [15:0] CFG_ADDR_PORT = 16'h0CF8;
    localparam logic [15:0] CFG_DATA_PORT = 16'h0CFC;
    localparam int          CFG_REG_BYTES = 4;
endpackage

// File: rtl/io_port_classify.sv
// Classifies a port access by port number and size.
// Assumes PORT_W > 16. The result TGT_CFG_SPACE means the access falls in
// the data window. The enable bit is resolved later.
module io_port_classify #(
    parameter int PORT_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [PORT_W-1:0]     port,
    input  logic [SIZE_W-1:0]     size,
    output io_dec_pkg::io_tgt_e   cls
);
    import io_dec_pkg::*;

    localparam int HI_W = PORT_W - 16;

    logic hi_set;
    logic is_addr_port;
    logic in_window;

    assign hi_set       = |port[PORT_W-1:16];
    assign is_addr_port = (port[15:0] == CFG_ADDR_PORT) && (size == SIZE_W'(CFG_REG_BYTES));
    assign in_window    = (port[15:2] == CFG_DATA_PORT[15:2]);

    // Priority: illegal port first, then register port, then window, then plain I/O.
    always_comb begin
        if (hi_set)            cls = TGT_ILLEGAL;
        else if (is_addr_port) cls = TGT_CFG_ADDR;
        else if (in_window)    cls = TGT_CFG_SPACE;
        else                   cls = TGT_IO;
    end
endmodule

// File: rtl/io_cfg_addr_reg.sv
// Holds the configuration-address register.
// The register is loaded on a qualified full-width write and cleared by reset.
module io_cfg_addr_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Loads the register on a write and clears it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/io_addr_former.sv
// Forms the final target, physical address and read data from the class,
// the port and the stored configuration address. Assumes DATA_W == 32.
module io_addr_former #(
    parameter int                 PADDR_W  = 64,
    parameter int                 DATA_W   = 32,
    parameter logic [PADDR_W-1:0] IO_BASE  = 64'h2000_0000_0000_0000,
    parameter logic [PADDR_W-1:0] CFG_BASE = 64'h3000_0000_0000_0000
) (
    input  io_dec_pkg::io_tgt_e  cls,
    input  logic [15:0]          port16,
    input  logic                 write,
    input  logic [DATA_W-1:0]    cfg_q,
    output io_dec_pkg::io_tgt_e  tgt,
    output logic [PADDR_W-1:0]   paddr,
    output logic [DATA_W-1:0]    rdata
);
    import io_dec_pkg::*;

    localparam int EN_BIT = DATA_W - 1;

    logic [PADDR_W-1:0] io_addr;
    logic [PADDR_W-1:0] cfg_addr;

    assign io_addr  = IO_BASE  | PADDR_W'(port16);
    assign cfg_addr = CFG_BASE | PADDR_W'(cfg_q[EN_BIT-1:0]);

    // Resolves the window enable and selects address and read data.
    always_comb begin
        tgt   = cls;
        paddr = '0;
        rdata = '0;
        unique case (cls)
            TGT_IO: paddr = io_addr;
            TGT_CFG_ADDR: if (!write) rdata = cfg_q;
            TGT_CFG_SPACE: begin
                if (cfg_q[EN_BIT]) begin
                    paddr = cfg_addr;
                end else begin
                    tgt = TGT_NONE;
                    if (!write) rdata = '1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/io_port_decoder.sv
// Top module of the legacy I/O port decoder. The decode is combinational
// and is followed by a single output register stage, so one request can be
// accepted in every cycle. Reset is synchronous and active low.
module io_port_decoder #(
    parameter int                 PORT_W   = 32,
    parameter int                 SIZE_W   = 3,
    parameter int                 DATA_W   = 32,
    parameter int                 PADDR_W  = 64,
    parameter logic [PADDR_W-1:0] IO_BASE  = 64'h2000_0000_0000_0000,
    parameter logic [PADDR_W-1:0] CFG_BASE = 64'h3000_0000_0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PORT_W-1:0]  req_port,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [2:0]         rsp_target,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic [DATA_W-1:0]  rsp_rdata
);
    import io_dec_pkg::*;

    io_tgt_e            cls;
    io_tgt_e            tgt_d;
    logic [PADDR_W-1:0] paddr_d;
    logic [DATA_W-1:0]  rdata_d;
    logic [DATA_W-1:0]  cfg_q;
    logic               cfg_wr;

    io_port_classify #(.PORT_W(PORT_W), .SIZE_W(SIZE_W)) u_classify (
        .port (req_port),
        .size (req_size),
        .cls  (cls)
    );

    assign cfg_wr = req_valid && req_write && (cls == TGT_CFG_ADDR);

    io_cfg_addr_reg #(.DATA_W(DATA_W)) u_cfg_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (req_wdata),
        .q     (cfg_q)
    );

    io_addr_former #(
        .PADDR_W (PADDR_W),
        .DATA_W  (DATA_W),
        .IO_BASE (IO_BASE),
        .CFG_BASE(CFG_BASE)
    ) u_former (
        .cls    (cls),
        .port16 (req_port[15:0]),
        .write  (req_write),
        .cfg_q  (cfg_q),
        .tgt    (tgt_d),
        .paddr  (paddr_d),
        .rdata  (rdata_d)
    );

    // Output stage. Registers one response per accepted request and holds zeros when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_target <= 3'd0;
            rsp_paddr  <= '0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_target <= tgt_d;
            rsp_paddr  <= paddr_d;
            rsp_rdata  <= rdata_d;
        end
    end
endmodule

// File: rtl/io_port_decoder_chk.sv
// Checker for io_port_decoder. It observes only the top-level ports and is
// attached with the bind statement at the end of this file.
module io_port_decoder_chk #(
    parameter int                 PORT_W   = 32,
    parameter int                 SIZE_W   = 3,
    parameter int                 DATA_W   = 32,
    parameter int                 PADDR_W  = 64,
    parameter logic [PADDR_W-1:0] IO_BASE  = 64'h2000_0000_0000_0000,
    parameter logic [PADDR_W-1:0] CFG_BASE = 64'h3000_0000_0000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [PORT_W-1:0]  req_port,
    input logic [SIZE_W-1:0]  req_size,
    input logic               req_write,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               rsp_valid,
    input logic [2:0]         rsp_target,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic [DATA_W-1:0]  rsp_rdata
);
    logic plain_port;
    assign plain_port = (req_port[PORT_W-1:16] == '0) && (req_port[15:2] != 14'h033F)
                        && (req_port[15:0] != 16'h0CF8);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R9
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    illegal_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_port[PORT_W-1:16] != '0)) |=> (rsp_target == 3'd4 && rsp_paddr == '0));
    // R5
    short_addr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_port == PORT_W'(16'h0CF8) && req_size != SIZE_W'(4)) |=> (rsp_target == 3'd0));
    // R8
    plain_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && plain_port) |=> (rsp_target == 3'd0 && rsp_paddr == (IO_BASE | PADDR_W'($past(req_port[15:0])))));
    // R6
    cfg_space_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_target == 3'd2) |-> ((rsp_paddr & ~(CFG_BASE | PADDR_W'(32'h7FFF_FFFF))) == '0));
    // R7
    no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_target == 3'd3) |-> (rsp_paddr == '0 && (rsp_rdata == '1 || rsp_rdata == '0)));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rsp_valid && rsp_target == 3'd0));
endmodule

bind io_port_decoder io_port_decoder_chk #(
    .PORT_W(PORT_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .PADDR_W(PADDR_W),
    .IO_BASE(IO_BASE), .CFG_BASE(CFG_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_paddr(rsp_paddr),
    .rsp_rdata(rsp_rdata)
);

// File: tb/io_port_decoder_tb.sv
`timescale 1ns/1ps
module io_port_decoder_tb;
    localparam logic [63:0] IOB  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] CFGB = 64'h3000_0000_0000_0000;

    typedef struct packed {
        logic [31:0] port;
        logic [2:0]  size;
        logic        wr;
        logic [31:0] wdata;
        logic [2:0]  tgt;
        logic [63:0] paddr;
        logic [31:0] rdata;
    } vec_t;

    // The table is applied back to back. Entries whose result depends on the register rely on this order.
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0CF8, 3'd4, 1'b0, 32'h0, 3'd1, 64'h0, 32'h0},                     // R3 R1 register starts at 0
        '{32'h0CFC, 3'd4, 1'b0, 32'h0, 3'd3, 64'h0, 32'hFFFF_FFFF},             // R7
        '{32'h0CF8, 3'd2, 1'b1, 32'h8000_1234, 3'd0, IOB | 64'h0CF8, 32'h0},   // R5
        '{32'h0CF8, 3'd4, 1'b0, 32'h0, 3'd1, 64'h0, 32'h0},                     // R5 no update
        '{32'h0CF8, 3'd4, 1'b1, 32'h8001_0A0C, 3'd1, 64'h0, 32'h0},             // R4
        '{32'h0CF8, 3'd4, 1'b0, 32'h0, 3'd1, 64'h0, 32'h8001_0A0C},             // R4 R3
        '{32'h0CFE, 3'd1, 1'b0, 32'h0, 3'd2, CFGB | 64'h0001_0A0C, 32'h0},      // R6
        '{32'h0CFD, 3'd1, 1'b1, 32'h55, 3'd2, CFGB | 64'h0001_0A0C, 32'h0},     // R6
        '{32'h0060, 3'd1, 1'b0, 32'h0, 3'd0, IOB | 64'h0060, 32'h0},            // R8
        '{32'hFFFF, 3'd2, 1'b0, 32'h0, 3'd0, IOB | 64'hFFFF, 32'h0},            // R8
        '{32'h0CFB, 3'd1, 1'b0, 32'h0, 3'd0, IOB | 64'h0CFB, 32'h0},            // R8
        '{32'h0D00, 3'd1, 1'b0, 32'h0, 3'd0, IOB | 64'h0D00, 32'h0},            // R8
        '{32'h1_0CF8, 3'd4, 1'b1, 32'h0, 3'd4, 64'h0, 32'h0},                   // R2
        '{32'h0CF8, 3'd4, 1'b0, 32'h0, 3'd1, 64'h0, 32'h8001_0A0C},             // R2 no update
        '{32'h0CF8, 3'd4, 1'b1, 32'h7FFF_FFFF, 3'd1, 64'h0, 32'h0},             // R4
        '{32'h0CFC, 3'd4, 1'b0, 32'h0, 3'd3, 64'h0, 32'hFFFF_FFFF},             // R7
        '{32'h0CFF, 3'd4, 1'b1, 32'h0, 3'd3, 64'h0, 32'h0}                      // R7 write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_port = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_target;
    logic [63:0] rsp_paddr;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    io_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_paddr(rsp_paddr),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] p, input logic [2:0] s,
                         input logic w, input logic [31:0] d);
        @(negedge clk);
        req_valid = v; req_port = p; req_size = s; req_write = w; req_wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", 64'(rsp_valid), 64'd0);
        check("R1 target", 64'(rsp_target), 64'd0);
        check("R1 paddr", rsp_paddr, 64'd0);
        check("R1 rdata", 64'(rsp_rdata), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].port, VECS[i].size, VECS[i].wr, VECS[i].wdata);
            check($sformatf("R9 valid v%0d", i), 64'(rsp_valid), 64'd1);
            check($sformatf("R2-8 target v%0d", i), 64'(rsp_target), 64'(VECS[i].tgt));
            check($sformatf("R2-8 paddr v%0d", i), rsp_paddr, VECS[i].paddr);
            check($sformatf("R3 R7 rdata v%0d", i), 64'(rsp_rdata), 64'(VECS[i].rdata));
        end

        // R9: an idle cycle gives no response.
        drive(1'b0, 32'h0060, 3'd1, 1'b0, 32'h0);
        check("R9 idle", 64'(rsp_valid), 64'd0);

        // R1: reset in mid-run clears the register.
        drive(1'b1, 32'h0CF8, 3'd4, 1'b1, 32'h8000_0100);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 valid after reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 32'h0CF8, 3'd4, 1'b0, 32'h0);
        check("R1 register cleared", 64'(rsp_rdata), 64'd0);
        drive(1'b1, 32'h0CFC, 3'd2, 1'b0, 32'h0);
        check("R7 after reset", 64'(rsp_target), 64'd3);

        // R6: write with the enable bit set, then access the window in the next cycle.
        drive(1'b1, 32'h0CF8, 3'd4, 1'b1, 32'hFFFF_FFFC);
        drive(1'b1, 32'h0CFC, 3'd2, 1'b0, 32'h0);
        check("R6 target", 64'(rsp_target), 64'd2);
        check("R6 paddr", rsp_paddr, CFGB | 64'h7FFF_FFFC);

        @(negedge clk);
        req_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule